// File: doc/BRIEF.md
# Six-State Modulus Counter

This block is a 4-bit synchronous up counter that can be made to walk a cycle of exactly six states in four different ways. The counter core has an active-low clear, a parallel load with its own data word, a count enable and a carry-out. A 2-bit scheme select decides which detection feeds back into the core. Two schemes stay at 0 to 5: one pulls the clear low on a count of five, the other loads an all-zero word on a count of five. A third scheme loads ten whenever carry-out fires, so it cycles through 10 to 15. The fourth loads three on a count of eight, so it cycles through 3 to 8.

Clear, load and count all act on the rising clock edge, and clear takes priority over load, which takes priority over count. A synchronous active-low reset puts the counter on the first state of the selected scheme. When enable is low, every feedback action is suppressed and the state holds. The scheme select may change while the counter runs. The counter then steps by one until it reaches the terminal state of the new scheme.

Top module: `mod6_counter`

## Requirements
- R1: With `rst_n` low at a rising edge, the state becomes the first state of the scheme on `mode`: 0 for mode 0 and mode 1, 10 for mode 2, 3 for mode 3.
- R2: With `en` low (and `rst_n` high), the state does not change at a rising edge, whatever the scheme or state.
- R3: `carry_out` is 1 exactly when the state is 15 and `en` is 1.
- R4: In mode 0 (clear scheme), an enabled edge at state 5 drives the state to 0, so the cycle is 0,1,2,3,4,5.
- R5: In mode 1 (zero-load scheme), an enabled edge at state 5 drives the state to 0, so the cycle is 0,1,2,3,4,5.
- R6: In mode 2 (high-range scheme), an enabled edge with `carry_out` high loads 10, so the cycle is 10,11,12,13,14,15.
- R7: In mode 3 (offset scheme), an enabled edge at state 8 loads 3, so the cycle is 3,4,5,6,7,8.
- R8: At any enabled edge where the selected scheme's terminal state is not present, the state steps up by one modulo 16. This includes states outside the scheme's cycle after `mode` changes.
- R9: `cycle_end` is 1 exactly when `en` is 1 and the state equals the terminal state of the selected scheme: 5 for modes 0 and 1, 15 for mode 2, 8 for mode 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset to the scheme's first state |
| mode | input | 2 | Scheme select: 0 clear, 1 zero-load, 2 high-range, 3 offset |
| en | input | 1 | Count enable |
| count | output | 4 | Counter state |
| carry_out | output | 1 | High while the state is 15 and counting is enabled |
| cycle_end | output | 1 | High while the state is the scheme's terminal state and counting is enabled |

## Verification
The embedded properties check four things on every cycle: holding while disabled, the one-step increment away from a terminal state, the wrap target of each scheme, and that neither flag rises without the enable. Other behaviour shows up only in the bench's scenarios. This covers the reset landing point for each scheme, continuous six-state cycles over many periods, and the path from a state outside a scheme's cycle after a live change of `mode`, which passes through 15 and on to 0. It also covers the exact value of both flags in each state, including a disabled edge that sits on a terminal state.

// File: rtl/mod6_counter.sv
module mod6_counter #(
  parameter int W        = 4,
  parameter int LOW_TOP  = 5,
  parameter int HI_BASE  = 10,
  parameter int OFS_BASE = 3,
  parameter int OFS_TOP  = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         en,
  output logic [W-1:0] count,
  output logic         carry_out,
  output logic         cycle_end
);
  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] LOW_T    = W'(LOW_TOP);
  localparam logic [W-1:0] HI_B     = W'(HI_BASE);
  localparam logic [W-1:0] OFS_B    = W'(OFS_BASE);
  localparam logic [W-1:0] OFS_T    = W'(OFS_TOP);

  logic         clr_n;
  logic         ld;
  logic [W-1:0] din;
  logic [W-1:0] start;
  logic [W-1:0] q;

  assign carry_out = en && (q == ALL_ONES);

  always_comb begin
    clr_n = 1'b1;
    ld    = 1'b0;
    din   = '0;
    start = '0;
    unique case (mode)
      2'd0: clr_n = !(en && (q == LOW_T));
      2'd1: ld    = en && (q == LOW_T);
      2'd2: begin
        ld    = carry_out;
        din   = HI_B;
        start = HI_B;
      end
      default: begin
        ld    = en && (q == OFS_T);
        din   = OFS_B;
        start = OFS_B;
      end
    endcase
  end

  assign cycle_end = !clr_n || ld;

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= start;
    else if (!clr_n) q <= '0;
    else if (ld)     q <= din;
    else if (en)     q <= q + 1'b1;
  end

  assign count = q;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q)); // R2
  AST_CARRY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> en); // R3
  AST_CLEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && en && q == LOW_T) |=> q == '0); // R4
  AST_ZERO_LOAD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && en && q == LOW_T) |=> q == '0); // R5
  AST_HIGH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && carry_out) |=> q == HI_B); // R6
  AST_OFFSET_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && en && q == OFS_T) |=> q == OFS_B); // R7
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cycle_end) |=> q == W'($past(q) + 1'b1)); // R8
  AST_END_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |-> en); // R9
endmodule

// File: tb/sim_mod6_counter.sv
`timescale 1ns/1ps
module sim_mod6_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       en = 1'b0;
  logic [3:0] count;
  logic       carry_out;
  logic       cycle_end;

  int applied = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  mod6_counter u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .en(en),
    .count(count), .carry_out(carry_out), .cycle_end(cycle_end)
  );

  // {rst_n, mode[1:0], en, exp_count[3:0], exp_carry, exp_end}
  localparam int NV = 29;
  localparam logic [9:0] VEC [NV] = '{
    {1'b0, 2'd2, 1'b1, 4'd10, 1'b0, 1'b0},  // R1
    {1'b1, 2'd2, 1'b1, 4'd11, 1'b0, 1'b0},
    {1'b1, 2'd2, 1'b1, 4'd12, 1'b0, 1'b0},
    {1'b1, 2'd2, 1'b1, 4'd13, 1'b0, 1'b0},
    {1'b1, 2'd2, 1'b1, 4'd14, 1'b0, 1'b0},
    {1'b1, 2'd2, 1'b1, 4'd15, 1'b1, 1'b1},  // R3 R9
    {1'b1, 2'd2, 1'b0, 4'd15, 1'b0, 1'b0},  // R2
    {1'b1, 2'd2, 1'b1, 4'd10, 1'b0, 1'b0},  // R6
    {1'b1, 2'd2, 1'b1, 4'd11, 1'b0, 1'b0},
    {1'b1, 2'd2, 1'b1, 4'd12, 1'b0, 1'b0},
    {1'b1, 2'd0, 1'b1, 4'd13, 1'b0, 1'b0},  // R8
    {1'b1, 2'd0, 1'b1, 4'd14, 1'b0, 1'b0},
    {1'b1, 2'd0, 1'b1, 4'd15, 1'b1, 1'b0},
    {1'b1, 2'd0, 1'b1, 4'd0,  1'b0, 1'b0},
    {1'b1, 2'd3, 1'b1, 4'd1,  1'b0, 1'b0},
    {1'b1, 2'd3, 1'b1, 4'd2,  1'b0, 1'b0},
    {1'b1, 2'd3, 1'b1, 4'd3,  1'b0, 1'b0},
    {1'b1, 2'd3, 1'b1, 4'd4,  1'b0, 1'b0},
    {1'b1, 2'd3, 1'b1, 4'd5,  1'b0, 1'b0},
    {1'b1, 2'd3, 1'b1, 4'd6,  1'b0, 1'b0},
    {1'b1, 2'd3, 1'b1, 4'd7,  1'b0, 1'b0},
    {1'b1, 2'd3, 1'b1, 4'd8,  1'b0, 1'b1},
    {1'b1, 2'd3, 1'b1, 4'd3,  1'b0, 1'b0},  // R7
    {1'b1, 2'd1, 1'b1, 4'd4,  1'b0, 1'b0},
    {1'b1, 2'd1, 1'b1, 4'd5,  1'b0, 1'b1},
    {1'b1, 2'd1, 1'b0, 4'd5,  1'b0, 1'b0},  // R2 at terminal
    {1'b1, 2'd1, 1'b1, 4'd0,  1'b0, 1'b0},  // R5
    {1'b0, 2'd3, 1'b1, 4'd3,  1'b0, 1'b0},  // R1
    {1'b0, 2'd1, 1'b1, 4'd0,  1'b0, 1'b0}   // R1
  };

  task automatic check(input string req, input logic [3:0] ec, input logic ecy, input logic ee);
    applied++;
    if (count !== ec || carry_out !== ecy || cycle_end !== ee) begin
      bad++;
      $display("FAIL %s: count=%0d carry=%b end=%b, expected count=%0d carry=%b end=%b",
               req, count, carry_out, cycle_end, ec, ecy, ee);
    end
  endtask

  function automatic logic [3:0] base_of(input logic [1:0] m);
    case (m)
      2'd2:    return 4'd10;
      2'd3:    return 4'd3;
      default: return 4'd0;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rst_n = VEC[i][9];
      mode  = VEC[i][8:7];
      en    = VEC[i][6];
      @(posedge clk);
      #1;
      check($sformatf("vec%0d R1-R9 table", i), VEC[i][5:2], VEC[i][1], VEC[i][0]);
    end
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      rst_n = 1'b0; mode = 2'(m); en = 1'b1;
      @(posedge clk); #1;
      check("R1 reset start", base_of(2'(m)), 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 1; k <= 24; k++) begin
        logic [3:0] e;
        @(posedge clk); #1;
        e = base_of(2'(m)) + 4'(k % 6);
        case (m)
          0: check("R4 clear cycle", e, e == 4'd15, (k % 6) == 5);
          1: check("R5 zero-load cycle", e, e == 4'd15, (k % 6) == 5);
          2: check("R6 high cycle", e, e == 4'd15, (k % 6) == 5);
          default: check("R7 offset cycle", e, e == 4'd15, (k % 6) == 5);
        endcase
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      bad++;
      $display("FAIL watchdog: cycles=%0d, expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule